// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block divides a 32768 Hz reference, delivered as a one-cycle enable on the system clock, down to a periodic event rate chosen by a 4-bit rate code. A free-running reference counter advances on every reference enable. A tick is produced whenever that count reaches a multiple of the selected period, so ticks always sit on period boundaries of the same time base. The counter keeps running whether or not the divider is enabled.

Each tick gives three results. A one-cycle event strobe is produced whenever the divider runs. A flag-set request asks the status logic to set its interrupt-request and periodic flags (mask 0xC0) and is produced only when periodic interrupts are enabled. A square-wave pulse is produced only when the square-wave output is enabled; it is a single pulse, not a toggling wave. The rate code is nonlinear: code 0 stops the divider, codes 1 and 2 alias onto slower periods, and codes 3 to 15 double the period with each step.

Top module: `piv_divider`

## Requirements
- R1: After reset, `per_tick`, `flag_set` and `sqw_pulse` are 0 and the reference count is 0, so with code 3 enabled straight after reset the first tick follows the 4th reference enable.
- R2: With `rate_code` = 0 no tick, flag request or pulse is produced, whatever the enables.
- R3: Code 1 gives a period of 128 reference cycles and code 2 a period of 256.
- R4: Codes 3 to 15 give a period of 2^(code-1) reference cycles.
- R5: With both `pie_en` and `sqwe_en` low, no tick is produced for any code.
- R6: A tick occurs on the reference enable that brings the free-running count (which counts even while the divider is off) to a multiple of the period.
- R7: `flag_set` is high together with `per_tick` exactly when `pie_en` was high on the tick's reference enable, and never otherwise.
- R8: `sqw_pulse` goes high on a tick when `sqwe_en` is high and stays high for exactly one reference interval, falling on the next reference enable.
- R9: A change of rate code takes effect at the next boundary of the new period, with no tick at the old boundary.
- R10: `per_tick` is high for exactly one system-clock cycle per tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable at the 32768 Hz reference rate |
| rate_code | input | 4 | Rate select; 0 stops, 1 and 2 alias to 128/256, else 2^(code-1) |
| pie_en | input | 1 | Periodic interrupt enable |
| sqwe_en | input | 1 | Square-wave pulse enable |
| per_tick | output | 1 | One-cycle periodic event strobe |
| flag_set | output | 1 | Request to set the 0xC0 status flags and raise the interrupt |
| sqw_pulse | output | 1 | Square-wave pulse, one reference interval long |

## Verification
The tick decision is taken in the cycle where `ref_tick` is high, using the rate code and enables present in that cycle. `per_tick` and `flag_set` are registered and show in the following cycle only, and `sqw_pulse` holds from that cycle until the clock edge after the next reference enable. The bench drives each reference enable on a falling edge. It checks all three outputs on the next falling edge, then checks one cycle later that `per_tick` has dropped while `sqw_pulse` holds. A reference model of the count and period, kept in the bench, decides which enables must tick.

// File: rtl/piv_pkg.sv
package piv_pkg;
  parameter int CODE_W = 4;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int CNT_W = NUM_CODES - 1;
  parameter int ALIAS_ONE = 8;
  parameter int ALIAS_TWO = 9;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  function automatic code_t effective_code(input code_t code);
    code_t e;
    case (code)
      code_t'(1): e = code_t'(ALIAS_ONE);
      code_t'(2): e = code_t'(ALIAS_TWO);
      default:    e = code;
    endcase
    return e;
  endfunction

  function automatic cnt_t boundary_mask(input code_t code);
    code_t e;
    cnt_t  m;
    e = effective_code(code);
    if (e == '0) m = '0;
    else         m = (cnt_t'(1) << (e - code_t'(1))) - cnt_t'(1);
    return m;
  endfunction
endpackage

// File: rtl/piv_rate_decode.sv
module piv_rate_decode
  import piv_pkg::*;
(
  input  logic  [CODE_W-1:0] rate_code,
  input  logic               pie_en,
  input  logic               sqwe_en,
  output logic  [CNT_W-1:0]  mask,
  output logic               active
);
  assign mask   = boundary_mask(rate_code);
  assign active = (rate_code != '0) && (pie_en || sqwe_en);
endmodule

// File: rtl/piv_ref_counter.sv
module piv_ref_counter
  import piv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  assign cnt_nxt = cnt_q + cnt_t'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (ref_tick) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/piv_tick_gen.sv
module piv_tick_gen
  import piv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] mask,
  input  logic             active,
  input  logic             pie_en,
  input  logic             sqwe_en,
  output logic             boundary,
  output logic             per_tick,
  output logic             flag_set,
  output logic             sqw_pulse
);
  assign boundary = ref_tick && active && ((cnt_nxt & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_tick  <= 1'b0;
      flag_set  <= 1'b0;
      sqw_pulse <= 1'b0;
    end else begin
      per_tick <= boundary;
      flag_set <= boundary && pie_en;
      if (ref_tick) sqw_pulse <= boundary && sqwe_en;
    end
  end

  AST_TICK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |-> ((cnt_q & $past(mask)) == '0)); // R6

  AST_SQW_FALLS_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sqw_pulse) |-> $past(ref_tick)); // R8

  AST_SQW_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqw_pulse) |-> per_tick); // R8
endmodule

// File: rtl/piv_divider.sv
module piv_divider
  import piv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              pie_en,
  input  logic              sqwe_en,
  output logic              per_tick,
  output logic              flag_set,
  output logic              sqw_pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] mask;
  logic             active;
  logic             boundary;

  piv_rate_decode u_decode (
    .rate_code (rate_code),
    .pie_en    (pie_en),
    .sqwe_en   (sqwe_en),
    .mask      (mask),
    .active    (active)
  );

  piv_ref_counter u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt)
  );

  piv_tick_gen u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .cnt_nxt   (cnt_nxt),
    .cnt_q     (cnt_q),
    .mask      (mask),
    .active    (active),
    .pie_en    (pie_en),
    .sqwe_en   (sqwe_en),
    .boundary  (boundary),
    .per_tick  (per_tick),
    .flag_set  (flag_set),
    .sqw_pulse (sqw_pulse)
  );

  AST_TICK_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |=> !per_tick); // R10

  AST_FLAG_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> per_tick); // R7

  AST_FLAG_NEEDS_PIE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> $past(pie_en)); // R7

  AST_NO_TICK_CODE0: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |-> ($past(rate_code) != '0)); // R2

  AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |-> ($past(pie_en) || $past(sqwe_en))); // R5
endmodule

// File: tb/piv_divider_tb.sv
module piv_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       pie_en = 1'b0;
  logic       sqwe_en = 1'b0;
  logic       per_tick, flag_set, sqw_pulse;

  int checks = 0;
  int failures = 0;
  int ticks_seen = 0;
  logic [14:0] ref_m = '0;
  string cur_tag = "R4";
  bit done = 1'b0;

  always #5 clk = ~clk;

  piv_divider u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rate_code(rate_code),
    .pie_en(pie_en), .sqwe_en(sqwe_en),
    .per_tick(per_tick), .flag_set(flag_set), .sqw_pulse(sqw_pulse)
  );

  // {code[3:0], pie, sqwe, refs[5:0]}
  localparam logic [11:0] VEC [8] = '{
    {4'd3, 1'b1, 1'b0, 6'd16},
    {4'd4, 1'b1, 1'b1, 6'd20},
    {4'd5, 1'b0, 1'b1, 6'd40},
    {4'd6, 1'b1, 1'b0, 6'd40},
    {4'd3, 1'b0, 1'b1, 6'd9},
    {4'd7, 1'b1, 1'b1, 6'd63},
    {4'd4, 1'b1, 1'b0, 6'd12},
    {4'd3, 1'b1, 1'b1, 6'd8}
  };

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b at ref count %0d", tag, act, exp, ref_m);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int period_of(input logic [3:0] c);
    if (c == 4'd1) return 128;
    if (c == 4'd2) return 256;
    return 1 << (int'(c) - 1);
  endfunction

  task automatic ref_step();
    logic exp_t;
    int   p;
    ref_m = ref_m + 15'd1;
    exp_t = 1'b0;
    if (rate_code != 4'd0 && (pie_en || sqwe_en)) begin
      p = period_of(rate_code);
      exp_t = ((int'(ref_m) % p) == 0);
    end
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    check(per_tick, exp_t, cur_tag);
    check(flag_set, exp_t && pie_en, "R7");
    check(sqw_pulse, exp_t && sqwe_en, "R8");
    if (per_tick) ticks_seen++;
    @(negedge clk);
    check(per_tick, 1'b0, "R10");
    check(flag_set, 1'b0, "R7");
    check(sqw_pulse, exp_t && sqwe_en, "R8");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) ref_step();
  endtask

  function automatic int ticks_between(input int s, input int n, input int p);
    return ((s + n) / p) - (s / p);
  endfunction

  initial begin
    int start;
    repeat (3) @(negedge clk);
    check(per_tick, 1'b0, "R1");
    check(flag_set, 1'b0, "R1");
    check(sqw_pulse, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(per_tick, 1'b0, "R1");

    // R1: counter starts at zero, first tick after 4th reference enable
    rate_code = 4'd3; pie_en = 1'b1;
    cur_tag = "R1";
    ticks_seen = 0;
    run(3);
    check_int(ticks_seen, 0, "R1");
    run(1);
    check_int(ticks_seen, 1, "R1");

    // R4: table of codes and enables
    cur_tag = "R4";
    for (int v = 0; v < 8; v++) begin
      rate_code = VEC[v][11:8];
      pie_en    = VEC[v][7];
      sqwe_en   = VEC[v][6];
      start = int'(ref_m);
      ticks_seen = 0;
      run(int'(VEC[v][5:0]));
      check_int(ticks_seen, ticks_between(start, int'(VEC[v][5:0]), period_of(VEC[v][11:8])), "R4");
    end

    // R2: code 0 with both enables
    cur_tag = "R2";
    rate_code = 4'd0; pie_en = 1'b1; sqwe_en = 1'b1;
    ticks_seen = 0;
    run(40);
    check_int(ticks_seen, 0, "R2");

    // R5: no enables
    cur_tag = "R5";
    rate_code = 4'd3; pie_en = 1'b0; sqwe_en = 1'b0;
    ticks_seen = 0;
    run(20);
    check_int(ticks_seen, 0, "R5");

    // R3: aliased codes 1 and 2
    cur_tag = "R3";
    rate_code = 4'd1; pie_en = 1'b1; sqwe_en = 1'b1;
    start = int'(ref_m);
    ticks_seen = 0;
    run(256);
    check_int(ticks_seen, ticks_between(start, 256, 128), "R3");
    rate_code = 4'd2;
    start = int'(ref_m);
    ticks_seen = 0;
    run(300);
    check_int(ticks_seen, ticks_between(start, 300, 256), "R3");

    // R6: count runs while disabled; first tick on a multiple of 8
    cur_tag = "R6";
    rate_code = 4'd4; pie_en = 1'b0; sqwe_en = 1'b0;
    while ((int'(ref_m) % 8) != 3) ref_step();
    pie_en = 1'b1;
    ticks_seen = 0;
    run(4);
    check_int(ticks_seen, 0, "R6");
    run(1);
    check_int(ticks_seen, 1, "R6");

    // R9: switch 4-period to 16-period just before an old boundary
    cur_tag = "R9";
    rate_code = 4'd3;
    while ((int'(ref_m) % 16) != 6) ref_step();
    rate_code = 4'd5;
    ticks_seen = 0;
    run(9);
    check_int(ticks_seen, 0, "R9");
    run(1);
    check_int(ticks_seen, 1, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule